// File: doc/BRIEF.md
# Charge Timer and Status Controller

This block is the digital sequencing core of a linear battery charger. A start request opens a charge cycle. The block then gates the charge path on, drives an active-low status indicator, and runs a termination timer that closes the cycle after a programmable number of timer ticks. The analog loop, the comparators and the resistor programming sit outside the block. It sees their results only as single-bit flags: constant-voltage phase, end-of-charge current reached, and battery below the recharge threshold.

When the input supply is in its reduced-current mode, the charge current drops to a fifth. To keep the total delivered charge about the same, the timer then advances at a fifth of its normal rate. This slowdown applies only while the charger is still in the constant-current phase. The end-of-charge decision is latched, so the status indicator releases once and stays released. That latch clears only on shutdown, on reset, or when the battery sags below the recharge threshold. A sag below that threshold after a timeout starts a fresh cycle.

Top module: `chg_timer_ctrl`

## Requirements
- R1: After reset, `chg_en_o`, `stat_pull_o` and `tmo_o` are all 0.
- R2: With no shutdown and no disable strap, `start_i` high in the idle state sets `chg_en_o`=1 and `stat_pull_o`=1 at the next clock edge, and clears the timer and the end-of-charge latch.
- R3: While charging with `hi_pwr_i`=1 or `cv_mode_i`=1, the timer advances once per clock. `tmo_o` rises exactly `timeout_cnt_i` clock edges after the start edge.
- R4: While charging with `hi_pwr_i`=0 and `cv_mode_i`=0, the timer advances once every 5 clocks (parameter `SLOW_DIV`). `tmo_o` rises 5×`timeout_cnt_i` edges after the start edge.
- R5: The slow-rate prescaler keeps its phase across a change of rate mode. It is cleared only when a cycle starts or restarts, or by shutdown.
- R6: While charging, `cv_mode_i`=1 together with `eoc_i`=1 sets `stat_pull_o`=0 at the next edge, and `chg_en_o` stays 1.
- R7: Once released by end-of-charge, `stat_pull_o` stays 0 when `eoc_i` falls again.
- R8: `eoc_i`=1 while `cv_mode_i`=0 has no effect on `stat_pull_o`.
- R9: `below_rchg_i`=1 clears the end-of-charge latch. During charging, `stat_pull_o` returns to 1 at the next edge.
- R10: On expiry with `below_rchg_i`=0, `chg_en_o`=0, `stat_pull_o`=0 and `tmo_o`=1.
- R11: In the timed-out state, `below_rchg_i`=1 starts a new cycle: `chg_en_o`=1, `stat_pull_o`=1, `tmo_o`=0, and the timer starts again from zero.
- R12: `shdn_i`=1 forces all three outputs to 0 at the next edge, clears the timer, and blocks `start_i`. A later start runs a full timeout.
- R13: `tmr_dis_i`=1 disables the charger in the same way as shutdown.
- R14: Expiry while `below_rchg_i`=1 keeps charging and restarts the timer from zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Base clock; one base timer tick per cycle |
| rst_n | input | 1 | Active-low power-up reset |
| start_i | input | 1 | Request to begin a charge cycle |
| shdn_i | input | 1 | Shutdown; turns the charger off and clears state |
| hi_pwr_i | input | 1 | 1 = full-current supply mode, 0 = reduced-current mode |
| cv_mode_i | input | 1 | Charger is in constant-voltage phase |
| eoc_i | input | 1 | End-of-charge current comparator output |
| below_rchg_i | input | 1 | Battery voltage is below the recharge threshold |
| tmr_dis_i | input | 1 | Timer-disable strap; turns the charger off |
| timeout_cnt_i | input | CNT_W | Timer ticks per charge cycle (1 or more) |
| chg_en_o | output | 1 | Charge path enable |
| stat_pull_o | output | 1 | Enable for the active-low status pull-down |
| tmo_o | output | 1 | Cycle ended by timeout |

## Verification
The properties assume that `timeout_cnt_i` stays constant during a cycle and is at least 1. They also assume that the status flags are synchronous to `clk`, so each flag is a clean level at every edge. The bench changes the timeout count and the rate-mode inputs only on the falling edge. It changes the timeout count only while the block is idle or shut down, and it never drives a zero timeout. Several properties exclude shutdown, the disable strap and the recharge flag in their antecedents, because those inputs take priority over everything else. The stimulus exercises those priorities only through separate directed cases.

// File: rtl/chg_pkg.sv
package chg_pkg;
   typedef enum logic [1:0] {
      CHG_IDLE = 2'd0,
      CHG_RUN  = 2'd1,
      CHG_DONE = 2'd2
   } chg_state_e;
endpackage

// File: rtl/chg_rate_div.sv
// Tick prescaler: passes every base tick in fast mode, one in DIV in slow mode.
module chg_rate_div #(
   parameter int DIV = 5
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clr,
   input  logic en,
   input  logic slow,
   output logic tick_o
);
   localparam int PW = (DIV > 1) ? $clog2(DIV) : 1;
   localparam logic [PW-1:0] LAST = PW'(DIV - 1);

   generate
      if (DIV < 1) begin : g_bad_div
         $error("chg_rate_div: DIV must be at least 1");
      end
      if (DIV == 1) begin : g_pass
         assign tick_o = 1'b1;
      end else begin : g_div
         logic [PW-1:0] phase_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               phase_q <= '0;
            end else if (clr) begin
               phase_q <= '0;
            end else if (en && slow) begin
               phase_q <= (phase_q == LAST) ? '0 : phase_q + 1'b1;
            end
         end
         assign tick_o = !slow || (phase_q == LAST);
      end
   endgenerate
endmodule

// File: rtl/chg_term_timer.sv
// Termination counter: counts qualified ticks, flags the tick that reaches the limit.
module chg_term_timer #(
   parameter int W = 16
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         clr,
   input  logic         run,
   input  logic         tick,
   input  logic [W-1:0] limit,
   output logic [W-1:0] cnt_o,
   output logic         expire_o
);
   logic [W-1:0] cnt_q;
   logic [W:0]   cnt_inc;

   assign cnt_inc  = {1'b0, cnt_q} + 1'b1;
   assign expire_o = run && tick && (cnt_inc >= {1'b0, limit});
   assign cnt_o    = cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (clr) begin
         cnt_q <= '0;
      end else if (run && tick && !expire_o) begin
         cnt_q <= cnt_inc[W-1:0];
      end
   end
endmodule

// File: rtl/chg_eoc_latch.sv
// Sticky end-of-charge flag; clear has priority over set.
module chg_eoc_latch (
   input  logic clk,
   input  logic rst_n,
   input  logic set,
   input  logic clr,
   output logic q
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         q <= 1'b0;
      end else if (clr) begin
         q <= 1'b0;
      end else if (set) begin
         q <= 1'b1;
      end
   end
endmodule

// File: rtl/chg_timer_ctrl.sv
module chg_timer_ctrl #(
   parameter int CNT_W    = 16,
   parameter int SLOW_DIV = 5
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start_i,
   input  logic             shdn_i,
   input  logic             hi_pwr_i,
   input  logic             cv_mode_i,
   input  logic             eoc_i,
   input  logic             below_rchg_i,
   input  logic             tmr_dis_i,
   input  logic [CNT_W-1:0] timeout_cnt_i,
   output logic             chg_en_o,
   output logic             stat_pull_o,
   output logic             tmo_o
);
   import chg_pkg::*;

   generate
      if (CNT_W < 1) begin : g_bad_w
         $error("chg_timer_ctrl: CNT_W must be at least 1");
      end
   endgenerate

   chg_state_e     st_q, st_d;
   logic           off, running, slow;
   logic           enter_run, restart, tmr_clr;
   logic           rate_tick, expire, eoc_q;
   logic [CNT_W-1:0] t_cnt;

   assign off       = shdn_i || tmr_dis_i;
   assign running   = (st_q == CHG_RUN) && !off;
   assign slow      = !hi_pwr_i && !cv_mode_i;
   assign enter_run = !off && (((st_q == CHG_IDLE) && start_i) ||
                               ((st_q == CHG_DONE) && (start_i || below_rchg_i)));
   assign restart   = running && expire && below_rchg_i;
   assign tmr_clr   = off || enter_run || restart;

   chg_rate_div #(.DIV(SLOW_DIV)) u_div (
      .clk    (clk),
      .rst_n  (rst_n),
      .clr    (tmr_clr),
      .en     (running),
      .slow   (slow),
      .tick_o (rate_tick)
   );

   chg_term_timer #(.W(CNT_W)) u_tmr (
      .clk      (clk),
      .rst_n    (rst_n),
      .clr      (tmr_clr),
      .run      (running),
      .tick     (rate_tick),
      .limit    (timeout_cnt_i),
      .cnt_o    (t_cnt),
      .expire_o (expire)
   );

   chg_eoc_latch u_eoc (
      .clk   (clk),
      .rst_n (rst_n),
      .set   (running && cv_mode_i && eoc_i),
      .clr   (off || below_rchg_i || enter_run),
      .q     (eoc_q)
   );

   always_comb begin
      st_d = st_q;
      if (off) begin
         st_d = CHG_IDLE;
      end else begin
         unique case (st_q)
            CHG_IDLE: if (start_i) st_d = CHG_RUN;
            CHG_RUN:  if (expire && !below_rchg_i) st_d = CHG_DONE;
            CHG_DONE: if (start_i || below_rchg_i) st_d = CHG_RUN;
            default:  st_d = CHG_IDLE;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) st_q <= CHG_IDLE;
      else        st_q <= st_d;
   end

   assign chg_en_o    = (st_q == CHG_RUN);
   assign stat_pull_o = (st_q == CHG_RUN) && !eoc_q;
   assign tmo_o       = (st_q == CHG_DONE);
endmodule

// File: rtl/chg_timer_ctrl_chk.sv
module chg_timer_ctrl_chk #(
   parameter int CNT_W = 16
) (
   input logic             clk,
   input logic             rst_n,
   input logic             shdn_i,
   input logic             tmr_dis_i,
   input logic             hi_pwr_i,
   input logic             cv_mode_i,
   input logic             eoc_i,
   input logic             below_rchg_i,
   input logic [CNT_W-1:0] timeout_cnt_i,
   input logic [CNT_W-1:0] cnt,
   input logic             chg_en_o,
   input logic             stat_pull_o,
   input logic             tmo_o
);
   logic quiet;
   assign quiet = !shdn_i && !tmr_dis_i && !below_rchg_i;

   // R12
   shdn_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
      shdn_i |=> (!chg_en_o && !stat_pull_o && !tmo_o));

   // R13
   strap_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
      tmr_dis_i |=> (!chg_en_o && !tmo_o));

   // R6
   eoc_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (chg_en_o && quiet && cv_mode_i && eoc_i) |=> !stat_pull_o);

   // R7
   eoc_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (chg_en_o && !stat_pull_o && quiet) |=> !stat_pull_o);

   // R3
   fast_rate_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (chg_en_o && quiet && (hi_pwr_i || cv_mode_i) &&
       (({1'b0, cnt} + 1'b1) < {1'b0, timeout_cnt_i}))
      |=> (cnt == $past(cnt) + 1'b1));

   // R10
   timeout_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(tmo_o) |-> ($past(chg_en_o) && !chg_en_o && !stat_pull_o));

   // R11
   recharge_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (tmo_o && below_rchg_i && !shdn_i && !tmr_dis_i)
      |=> (chg_en_o && stat_pull_o && !tmo_o && cnt == '0));
endmodule

bind chg_timer_ctrl chg_timer_ctrl_chk #(.CNT_W(CNT_W)) u_chk (
   .clk           (clk),
   .rst_n         (rst_n),
   .shdn_i        (shdn_i),
   .tmr_dis_i     (tmr_dis_i),
   .hi_pwr_i      (hi_pwr_i),
   .cv_mode_i     (cv_mode_i),
   .eoc_i         (eoc_i),
   .below_rchg_i  (below_rchg_i),
   .timeout_cnt_i (timeout_cnt_i),
   .cnt           (t_cnt),
   .chg_en_o      (chg_en_o),
   .stat_pull_o   (stat_pull_o),
   .tmo_o         (tmo_o)
);

// File: tb/tb_chg_timer_ctrl.sv
module tb_chg_timer_ctrl;
   localparam int CNT_W = 16;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             start_i = 1'b0, shdn_i = 1'b0, hi_pwr_i = 1'b1, cv_mode_i = 1'b0;
   logic             eoc_i = 1'b0, below_rchg_i = 1'b0, tmr_dis_i = 1'b0;
   logic [CNT_W-1:0] timeout_cnt_i = 16'd4;
   logic             chg_en_o, stat_pull_o, tmo_o;

   int checks = 0;
   int fails  = 0;
   int cyc    = 0;

   always #5 clk = ~clk;

   chg_timer_ctrl #(.CNT_W(CNT_W), .SLOW_DIV(5)) dut (
      .clk(clk), .rst_n(rst_n), .start_i(start_i), .shdn_i(shdn_i),
      .hi_pwr_i(hi_pwr_i), .cv_mode_i(cv_mode_i), .eoc_i(eoc_i),
      .below_rchg_i(below_rchg_i), .tmr_dis_i(tmr_dis_i),
      .timeout_cnt_i(timeout_cnt_i), .chg_en_o(chg_en_o),
      .stat_pull_o(stat_pull_o), .tmo_o(tmo_o)
   );

   // {hi_pwr, cv_mode, limit[7:0], expected edges[7:0]}
   localparam logic [17:0] VEC [6] = '{
      {1'b1, 1'b0, 8'd4, 8'd4},
      {1'b0, 1'b1, 8'd4, 8'd4},
      {1'b1, 1'b1, 8'd3, 8'd3},
      {1'b0, 1'b0, 8'd3, 8'd15},
      {1'b0, 1'b0, 8'd1, 8'd5},
      {1'b1, 1'b0, 8'd1, 8'd1}
   };

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic step();
      @(negedge clk);
   endtask

   task automatic begin_cycle();
      start_i = 1'b1;
      step();
      start_i = 1'b0;
   endtask

   task automatic count_to_tmo(output int n);
      n = 0;
      while (!tmo_o && n < 1000) begin
         step();
         n++;
      end
   endtask

   task automatic shut_pulse();
      shdn_i = 1'b1;
      step();
      shdn_i = 1'b0;
   endtask

   always @(posedge clk) begin
      cyc++;
      if (cyc > 100000) begin
         fails++;
         checks++;
         $display("FAIL watchdog: actual %0d expected %0d", cyc, 100000);
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end

   initial begin
      int n;
      repeat (3) step();
      // R1 reset state
      chk({chg_en_o, stat_pull_o, tmo_o} == 3'b000, "R1", {chg_en_o, stat_pull_o, tmo_o}, 0);
      rst_n = 1'b1;
      step();
      chk({chg_en_o, stat_pull_o, tmo_o} == 3'b000, "R1", {chg_en_o, stat_pull_o, tmo_o}, 0);

      // Table: rate modes R3 / R4
      for (int i = 0; i < 6; i++) begin
         shut_pulse();
         hi_pwr_i      = VEC[i][17];
         cv_mode_i     = VEC[i][16];
         timeout_cnt_i = CNT_W'(VEC[i][15:8]);
         begin_cycle();
         count_to_tmo(n);
         chk(n == int'(VEC[i][7:0]), (VEC[i][17] || VEC[i][16]) ? "R3" : "R4", n, int'(VEC[i][7:0]));
      end

      // R5 phase kept across mode change
      shut_pulse();
      hi_pwr_i = 1'b0; cv_mode_i = 1'b0; timeout_cnt_i = 16'd4;
      begin_cycle();
      repeat (7) step();
      hi_pwr_i = 1'b1;
      step();
      hi_pwr_i = 1'b0;
      count_to_tmo(n);
      chk(n == 8, "R5", n, 8);

      // R2 start
      shut_pulse();
      hi_pwr_i = 1'b1; timeout_cnt_i = 16'd200;
      begin_cycle();
      chk(chg_en_o && stat_pull_o && !tmo_o, "R2", {chg_en_o, stat_pull_o, tmo_o}, 3'b110);
      // R8 eoc outside constant-voltage ignored
      eoc_i = 1'b1; cv_mode_i = 1'b0;
      step(); step();
      chk(stat_pull_o == 1'b1, "R8", stat_pull_o, 1);
      // R6 release in constant-voltage
      cv_mode_i = 1'b1;
      step();
      chk(!stat_pull_o && chg_en_o, "R6", {stat_pull_o, chg_en_o}, 2'b01);
      // R7 sticky
      eoc_i = 1'b0;
      step(); step(); step();
      chk(!stat_pull_o && chg_en_o, "R7", {stat_pull_o, chg_en_o}, 2'b01);
      // R9 recharge flag clears latch
      below_rchg_i = 1'b1;
      step();
      below_rchg_i = 1'b0;
      chk(stat_pull_o == 1'b1, "R9", stat_pull_o, 1);

      // R10 timeout above threshold
      shut_pulse();
      cv_mode_i = 1'b0; hi_pwr_i = 1'b1; timeout_cnt_i = 16'd3;
      begin_cycle();
      count_to_tmo(n);
      chk(!chg_en_o && !stat_pull_o && tmo_o, "R10", {chg_en_o, stat_pull_o, tmo_o}, 3'b001);
      step(); step();
      chk(!chg_en_o && tmo_o, "R10", {chg_en_o, tmo_o}, 2'b01);
      // R11 recharge restart
      below_rchg_i = 1'b1;
      step();
      below_rchg_i = 1'b0;
      chk(chg_en_o && stat_pull_o && !tmo_o, "R11", {chg_en_o, stat_pull_o, tmo_o}, 3'b110);
      count_to_tmo(n);
      chk(n == 3, "R11", n, 3);

      // R14 expiry while below threshold keeps charging
      shut_pulse();
      timeout_cnt_i = 16'd3;
      below_rchg_i = 1'b1;
      begin_cycle();
      repeat (7) step();
      chk(chg_en_o && !tmo_o, "R14", {chg_en_o, tmo_o}, 2'b10);
      below_rchg_i = 1'b0;
      count_to_tmo(n);
      chk(n == 2, "R14", n, 2);

      // R12 shutdown mid-cycle
      shut_pulse();
      timeout_cnt_i = 16'd5;
      begin_cycle();
      repeat (3) step();
      shdn_i = 1'b1;
      step();
      chk({chg_en_o, stat_pull_o, tmo_o} == 3'b000, "R12", {chg_en_o, stat_pull_o, tmo_o}, 0);
      start_i = 1'b1;
      step();
      start_i = 1'b0;
      chk(!chg_en_o, "R12", chg_en_o, 0);
      shdn_i = 1'b0;
      begin_cycle();
      count_to_tmo(n);
      chk(n == 5, "R12", n, 5);

      // R13 timer-disable strap
      tmr_dis_i = 1'b1;
      begin_cycle();
      chk(!chg_en_o && !stat_pull_o, "R13", {chg_en_o, stat_pull_o}, 0);
      tmr_dis_i = 1'b0;
      begin_cycle();
      step();
      tmr_dis_i = 1'b1;
      step();
      chk({chg_en_o, stat_pull_o, tmo_o} == 3'b000, "R13", {chg_en_o, stat_pull_o, tmo_o}, 0);
      tmr_dis_i = 1'b0;

      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end
endmodule